// File: doc/BRIEF.md
# NMI-Aware Pending Interrupt Arbiter

This block picks the single best pending interrupt, out of a bank of private interrupt lines and one externally supplied message-interrupt candidate, and presents it to a processor. Each line has its own configuration inputs: pending, enable, a group bit (1 = non-secure group), a non-maskable flag and a programmed 8-bit priority. A non-maskable line does not use its programmed priority. It gets a substituted effective priority that depends on the disable-security control input and the line's group.

A one-cycle start pulse begins a sequential rescan. The arbiter visits one line per clock in ascending ID order and then spends one more cycle on the message candidate. When the scan ends it loads the result registers and raises a one-cycle done pulse. Lower numeric priority wins. At equal priority a non-maskable candidate wins. When both priority and NMI flag are equal, the lowest ID wins.

Top module: `nmi_intr_arbiter`

## Requirements
- R1: A line whose non-maskable flag is 1 ignores its programmed priority. Its effective priority is 0x80 when `sec_dis_i` is 0 and its group bit is 1 (non-secure). In every other case it is 0x00.
- R2: A line whose non-maskable flag is 0 uses its programmed 8-bit priority as its effective priority.
- R3: Between two candidates, the lower numeric effective priority wins, whatever their NMI flags are.
- R4: At equal effective priority, a candidate with the NMI flag set beats one without it.
- R5: At equal priority and equal NMI flag, a candidate replaces the current best when its ID is lower than or equal to the best's ID. The lowest line ID therefore wins, and the message candidate (compared last) wins such a tie only if its ID is lower than or equal to the best's.
- R6: After reset, and at every start, the running best record is set to priority 0xFF with the NMI flag cleared. After reset, `best_valid_o` and `done_o` are 0 and `best_prio_o` is 0xFF.
- R7: Only lines that are both pending and enabled take part in the selection.
- R8: The message candidate takes part only when `msg_en_i`, `msg_glb_en_i` and `ns_g1_en_i` are all 1 and `msg_prio_i` is not 0xFF. When it wins, it is reported with NMI flag 0 and group bit 1.
- R9: `done_o` is high for exactly one cycle, NUM_LINES+1 clock cycles after the edge that samples `start_i` high. The result outputs change only in the cycle in which `done_o` is high, and hold at all other times.
- R10: `best_valid_o` is 1 exactly when the final best priority is not 0xFF.
- R11: A start pulse during a scan restarts the scan from line 0 with a cleared record. `done_o` then follows NUM_LINES+1 cycles after the new start, and no earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin (or restart) a rescan |
| sec_dis_i | input | 1 | Disable-security control bit |
| line_pend_i | input | NUM_LINES | Per-line pending |
| line_en_i | input | NUM_LINES | Per-line enable |
| line_grp_i | input | NUM_LINES | Per-line group, 1 = non-secure |
| line_nmi_i | input | NUM_LINES | Per-line non-maskable flag |
| line_prio_i | input | NUM_LINES x 8 | Per-line programmed priority |
| msg_en_i | input | 1 | Message candidate local enable |
| msg_glb_en_i | input | 1 | Global message-interrupt enable |
| ns_g1_en_i | input | 1 | Non-secure group-1 enable |
| msg_prio_i | input | 8 | Message candidate priority |
| msg_id_i | input | 16 | Message candidate ID |
| best_id_o | output | 16 | Winning ID |
| best_prio_o | output | 8 | Winning effective priority |
| best_nmi_o | output | 1 | Winner is non-maskable |
| best_grp_o | output | 1 | Winner group, 1 = non-secure |
| best_valid_o | output | 1 | A winner with priority other than 0xFF exists |
| done_o | output | 1 | One-cycle end-of-scan pulse |

## Verification
The bench aims at ties. Priorities are drawn from a small set, so equal effective priorities between NMI and plain lines are common. A design that reversed the NMI tie rule, or that let the last visited line win ties instead of the first, would report the wrong ID. It also covers NMI lines in both groups with `sec_dis_i` set and cleared. A wrong priority substitution would show up as a wrong priority or a wrong winner. The message candidate is offered with each of its three enables dropped in turn, with priority 0xFF, and with IDs both below and above the winning line. A restart in mid-scan checks that `done_o` does not arrive on the old schedule and that stale state does not leak into the result.

// File: rtl/nia_pkg.sv
package nia_pkg;
    localparam int PRIO_W = 8;
    localparam int ID_W   = 16;

    localparam logic [PRIO_W-1:0] PRIO_IDLE   = '1;
    localparam logic [PRIO_W-1:0] PRIO_NMI_NS = 8'h80;
    localparam logic [PRIO_W-1:0] PRIO_NMI_TOP = 8'h00;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic              nmi;
        logic              grp;
    } cand_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_MSG  = 2'd2
    } phase_e;
endpackage

// File: rtl/nia_eff_prio.sv
module nia_eff_prio
    import nia_pkg::*;
(
    input  logic              nmi_i,
    input  logic              grp_ns_i,
    input  logic              sec_dis_i,
    input  logic [PRIO_W-1:0] prog_prio_i,
    output logic [PRIO_W-1:0] eff_prio_o
);
    always_comb begin
        if (!nmi_i) begin
            eff_prio_o = prog_prio_i;
        end else if (!sec_dis_i && grp_ns_i) begin
            eff_prio_o = PRIO_NMI_NS;
        end else begin
            eff_prio_o = PRIO_NMI_TOP;
        end
    end
endmodule

// File: rtl/nia_line_pick.sv
module nia_line_pick
    import nia_pkg::*;
#(
    parameter int NUM_LINES = 32,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                              sec_dis_i,
    input  logic [NUM_LINES-1:0]              pend_i,
    input  logic [NUM_LINES-1:0]              en_i,
    input  logic [NUM_LINES-1:0]              grp_i,
    input  logic [NUM_LINES-1:0]              nmi_i,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0]  prio_i,
    input  logic [IDX_W-1:0]                  idx_i,
    output cand_t                             cand_o,
    output logic                              elig_o
);
    logic [NUM_LINES-1:0][PRIO_W-1:0] eff_prio;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        nia_eff_prio u_map (
            .nmi_i      (nmi_i[g]),
            .grp_ns_i   (grp_i[g]),
            .sec_dis_i  (sec_dis_i),
            .prog_prio_i(prio_i[g]),
            .eff_prio_o (eff_prio[g])
        );
    end

    always_comb begin
        cand_o.id   = ID_W'(idx_i);
        cand_o.prio = eff_prio[idx_i];
        cand_o.nmi  = nmi_i[idx_i];
        cand_o.grp  = grp_i[idx_i];
        elig_o      = pend_i[idx_i] && en_i[idx_i];
    end
endmodule

// File: rtl/nia_rank_cmp.sv
module nia_rank_cmp
    import nia_pkg::*;
(
    input  cand_t cand_i,
    input  cand_t best_i,
    output logic  take_o
);
    always_comb begin
        if (cand_i.prio != best_i.prio) begin
            take_o = cand_i.prio < best_i.prio;
        end else if (cand_i.nmi != best_i.nmi) begin
            take_o = cand_i.nmi;
        end else begin
            take_o = cand_i.id <= best_i.id;
        end
    end
endmodule

// File: rtl/nmi_intr_arbiter.sv
module nmi_intr_arbiter
    import nia_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic                              sec_dis_i,
    input  logic [NUM_LINES-1:0]              line_pend_i,
    input  logic [NUM_LINES-1:0]              line_en_i,
    input  logic [NUM_LINES-1:0]              line_grp_i,
    input  logic [NUM_LINES-1:0]              line_nmi_i,
    input  logic [NUM_LINES-1:0][7:0]         line_prio_i,
    input  logic                              msg_en_i,
    input  logic                              msg_glb_en_i,
    input  logic                              ns_g1_en_i,
    input  logic [7:0]                        msg_prio_i,
    input  logic [15:0]                       msg_id_i,
    output logic [15:0]                       best_id_o,
    output logic [7:0]                        best_prio_o,
    output logic                              best_nmi_o,
    output logic                              best_grp_o,
    output logic                              best_valid_o,
    output logic                              done_o
);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);
    localparam cand_t CLEAR_REC = '{id: '1, prio: PRIO_IDLE, nmi: 1'b0, grp: 1'b0};

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
        cand_t            run;
        cand_t            res;
        logic             valid;
        logic             done;
    } state_t;

    state_t st_d, st_q;

    cand_t line_cand, msg_cand, eval_cand;
    logic  line_elig, msg_elig, eval_elig, take;

    nia_line_pick #(.NUM_LINES(NUM_LINES)) u_pick (
        .sec_dis_i(sec_dis_i),
        .pend_i   (line_pend_i),
        .en_i     (line_en_i),
        .grp_i    (line_grp_i),
        .nmi_i    (line_nmi_i),
        .prio_i   (line_prio_i),
        .idx_i    (st_q.idx),
        .cand_o   (line_cand),
        .elig_o   (line_elig)
    );

    always_comb begin
        msg_cand.id   = msg_id_i;
        msg_cand.prio = msg_prio_i;
        msg_cand.nmi  = 1'b0;
        msg_cand.grp  = 1'b1;
        msg_elig = msg_en_i && msg_glb_en_i && ns_g1_en_i && (msg_prio_i != PRIO_IDLE);
        if (st_q.phase == PH_MSG) begin
            eval_cand = msg_cand;
            eval_elig = msg_elig;
        end else begin
            eval_cand = line_cand;
            eval_elig = line_elig && (st_q.phase == PH_SCAN);
        end
    end

    nia_rank_cmp u_cmp (
        .cand_i(eval_cand),
        .best_i(st_q.run),
        .take_o(take)
    );

    always_comb begin
        cand_t upd;
        st_d      = st_q;
        st_d.done = 1'b0;
        upd       = (eval_elig && take) ? eval_cand : st_q.run;

        if (start_i) begin
            st_d.phase = PH_SCAN;
            st_d.idx   = '0;
            st_d.run   = CLEAR_REC;
        end else begin
            unique case (st_q.phase)
                PH_SCAN: begin
                    st_d.run = upd;
                    if (st_q.idx == LAST_IDX) begin
                        st_d.phase = PH_MSG;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
                PH_MSG: begin
                    st_d.run   = upd;
                    st_d.res   = upd;
                    st_d.valid = upd.prio != PRIO_IDLE;
                    st_d.done  = 1'b1;
                    st_d.phase = PH_IDLE;
                end
                default: begin
                    st_d.phase = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.idx   <= '0;
            st_q.run   <= CLEAR_REC;
            st_q.res   <= CLEAR_REC;
            st_q.valid <= 1'b0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign best_id_o    = st_q.res.id;
    assign best_prio_o  = st_q.res.prio;
    assign best_nmi_o   = st_q.res.nmi;
    assign best_grp_o   = st_q.res.grp;
    assign best_valid_o = st_q.valid;
    assign done_o       = st_q.done;

    AST_NMI_PRIO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (best_valid_o && best_nmi_o) |-> (best_prio_o == 8'h00 || best_prio_o == 8'h80)); // R1

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.run.prio == PRIO_IDLE && !st_q.run.nmi && st_q.phase == PH_SCAN && st_q.idx == '0)); // R6

    AST_MSG_NOT_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_MSG && !start_i && msg_elig && take) |=> (!st_q.run.nmi && st_q.run.grp)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(best_id_o) && $stable(best_prio_o) && $stable(best_nmi_o)
                     && $stable(best_grp_o) && $stable(best_valid_o))); // R9

    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid_o |-> (best_prio_o != 8'hFF)); // R10

    AST_NO_DONE_MID_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SCAN) |=> !done_o); // R11
endmodule

// File: tb/nmi_intr_arbiter_test.sv
module nmi_intr_arbiter_test;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sec_dis = 1'b0;
    logic [N-1:0] pend = '0, en = '0, grp = '0, nmi = '0;
    logic [N-1:0][7:0] prio = '0;
    logic m_en = 1'b0, m_glb = 1'b0, m_ns = 1'b0;
    logic [7:0] m_prio = 8'hFF;
    logic [15:0] m_id = 16'h2000;
    logic [15:0] o_id;
    logic [7:0] o_prio;
    logic o_nmi, o_grp, o_valid, o_done;

    int checks = 0;
    int fails = 0;
    bit hung = 1'b0;

    always #5 clk = ~clk;

    nmi_intr_arbiter #(.NUM_LINES(N)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sec_dis_i(sec_dis),
        .line_pend_i(pend), .line_en_i(en), .line_grp_i(grp), .line_nmi_i(nmi),
        .line_prio_i(prio), .msg_en_i(m_en), .msg_glb_en_i(m_glb), .ns_g1_en_i(m_ns),
        .msg_prio_i(m_prio), .msg_id_i(m_id), .best_id_o(o_id), .best_prio_o(o_prio),
        .best_nmi_o(o_nmi), .best_grp_o(o_grp), .best_valid_o(o_valid), .done_o(o_done)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected winner: smallest key {eff_prio, not_nmi, id}; message wins key ties (<=).
    logic [7:0]  e_prio;
    logic        e_nmi, e_grp, e_valid;
    logic [15:0] e_id;

    task automatic model();
        logic [24:0] best_key, k;
        logic [7:0] ep;
        best_key = {8'hFF, 1'b1, 16'hFFFF};
        e_grp = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && en[i]) begin
                ep = !nmi[i] ? prio[i] : ((!sec_dis && grp[i]) ? 8'h80 : 8'h00);
                k = {ep, ~nmi[i], 16'(i)};
                if (k < best_key) begin
                    best_key = k;
                    e_grp = grp[i];
                end
            end
        end
        if (m_en && m_glb && m_ns && m_prio != 8'hFF) begin
            k = {m_prio, 1'b1, m_id};
            if (k <= best_key) begin
                best_key = k;
                e_grp = 1'b1;
            end
        end
        e_prio  = best_key[24:17];
        e_nmi   = ~best_key[16];
        e_id    = best_key[15:0];
        e_valid = e_prio != 8'hFF;
    endtask

    // Pulse start, return the number of cycles until done is seen.
    task automatic run_scan(output int lat);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        lat = -1;
        for (int c = 1; c <= N + 8; c++) begin
            @(negedge clk);
            if (o_done && lat < 0) lat = c;
        end
    endtask

    task automatic compare(string req);
        model();
        check({req, " valid R10"}, o_valid, e_valid);
        if (e_valid) begin
            check({req, " prio"}, o_prio, e_prio);
            check({req, " nmi"}, o_nmi, e_nmi);
            check({req, " id"}, o_id, e_id);
            check({req, " grp"}, o_grp, e_grp);
        end
    endtask

    task automatic scan_and_compare(string req);
        int lat;
        run_scan(lat);
        check({req, " latency R9"}, lat, N + 1);
        compare(req);
    endtask

    function automatic logic [7:0] pick_prio();
        case ($urandom_range(0, 4))
            0: return 8'h00;
            1: return 8'h80;
            2: return 8'h40;
            3: return 8'hFF;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        int lat;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset valid", o_valid, 0);
        check("R6 reset done", o_done, 0);
        check("R6 reset prio", o_prio, 8'hFF);

        // Empty bank: nothing valid (R7, R10).
        scan_and_compare("R7 empty");

        // R2/R3: plain lines, lower value wins.
        pend = '1; en = '1;
        for (int i = 0; i < N; i++) prio[i] = 8'h90;
        prio[20] = 8'h10; prio[5] = 8'h11;
        scan_and_compare("R2 R3 plain");
        check("R3 winner", o_id, 20);

        // R7: disabled best line is skipped.
        en[20] = 1'b0;
        scan_and_compare("R7 disabled");
        check("R7 winner", o_id, 5);
        pend[5] = 1'b0;
        scan_and_compare("R7 not pending");

        // R1/R4: NMI non-secure at 0x80 ties a plain 0x80 line with lower ID.
        pend = '1; en = '1; nmi = '0; grp = '0;
        for (int i = 0; i < N; i++) prio[i] = 8'hA0;
        prio[3] = 8'h80;
        nmi[9] = 1'b1; grp[9] = 1'b1; prio[9] = 8'hFF; sec_dis = 1'b0;
        scan_and_compare("R1 R4 nmi tie");
        check("R4 winner", o_id, 9);
        check("R1 substituted prio", o_prio, 8'h80);

        // R1: disable-security set, NMI goes to 0x00.
        sec_dis = 1'b1;
        scan_and_compare("R1 secdis");
        check("R1 prio zero", o_prio, 8'h00);

        // R5: equal prio and flags, lowest ID wins; message with lower/higher ID.
        sec_dis = 1'b0; nmi = '0;
        for (int i = 0; i < N; i++) prio[i] = 8'h30;
        scan_and_compare("R5 tie");
        check("R5 lowest", o_id, 0);
        m_en = 1'b1; m_glb = 1'b1; m_ns = 1'b1; m_prio = 8'h30; m_id = 16'h0000;
        scan_and_compare("R5 msg equal id");
        check("R5 msg wins equal id", o_grp, 1);
        m_id = 16'h2000;
        scan_and_compare("R5 msg higher id");

        // R8: message enables and 0xFF gate.
        m_prio = 8'h05;
        scan_and_compare("R8 msg wins");
        check("R8 msg id", o_id, 16'h2000);
        check("R8 msg nmi", o_nmi, 0);
        m_en = 1'b0;  scan_and_compare("R8 local off");  m_en = 1'b1;
        m_glb = 1'b0; scan_and_compare("R8 global off"); m_glb = 1'b1;
        m_ns = 1'b0;  scan_and_compare("R8 group off");  m_ns = 1'b1;
        pend = '0; m_prio = 8'hFF;
        scan_and_compare("R8 msg prio FF");
        check("R8 FF not valid", o_valid, 0);

        // R11: restart mid-scan.
        pend = '1; prio[7] = 8'h01;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        lat = -1;
        for (int c = 1; c <= N + 8; c++) begin
            @(negedge clk);
            if (o_done && lat < 0) lat = c;
        end
        check("R11 restart latency", lat, N + 1);
        compare("R11 restart");

        // Constrained random sweep (R1-style mix of all rules).
        for (int t = 0; t < 120; t++) begin
            pend = N'($urandom); en = N'($urandom) | N'($urandom);
            grp = N'($urandom); nmi = N'($urandom) & N'($urandom) & N'($urandom);
            for (int i = 0; i < N; i++) prio[i] = pick_prio();
            sec_dis = 1'($urandom);
            m_en = ($urandom_range(0, 3) != 0); m_glb = ($urandom_range(0, 3) != 0);
            m_ns = ($urandom_range(0, 3) != 0);
            m_prio = pick_prio();
            m_id = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, N)) : 16'($urandom);
            scan_and_compare("R1 R4 R5 R8 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        hung = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule